// File: doc/BRIEF.md
# Two-Wire Bus Control Register

This block is the control and status layer that software uses to drive a two-wire serial bus controller. A simple register port lets software write and read an 8-bit control register and write a transmit data register. On the other side the block talks to a bit-level bus engine. The engine reports when a job is finished, whether it is acting as master, and which START and STOP events it has seen on the bus. The block sends the engine a go pulse, a start request, a stop request, a slave release pulse and an acknowledge enable level.

The central rule is a completion flag. Hardware sets it when the engine finishes a job. Only software clears it, by writing a one to its bit. That clear is also what launches the next engine operation. While the flag is set and the interface is enabled, the block tells the engine to keep the clock line held low. A start request is deferred while the bus is busy and is issued once a STOP is seen. A stop request in master mode clears itself after the STOP is executed. In slave mode the same request instead releases the bus lines. A data-register write made while the flag is low is rejected and recorded as a collision.

Top module: `twb_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, the transmit byte is 0, and every command, hold and interrupt output is low.
- R2: Control bit 7 is the completion flag. Any cycle with `eng_done` high sets it. A control write with bit 7 at one clears it, a write with bit 7 at zero leaves it alone, and `eng_done` wins over a clear made in the same cycle.
- R3: When a control write clears a set flag, with bit 2 (enable) at one in the written value and no `eng_done` in that cycle, `cmd_go` is high for exactly the one cycle after the write. `hold_scl` equals flag AND enable.
- R4: `irq` is high exactly when the flag, control bit 0 (interrupt enable) and `glob_irq_en` are all high.
- R5: Control bit 5 is the start request, and hardware never clears it. The bus counts as busy from a cycle with `eng_start_seen` until a cycle with `eng_stop_seen`, and is idle after reset. `cmd_start` is high while start request and enable are set and the bus is idle.
- R6: Control bit 4 is the stop request. In master mode (`eng_is_master` high), `cmd_stop` is high while stop request and enable are set. The bit clears the cycle after `eng_stop_done` unless a control write occurs in that same cycle.
- R7: A control write with bit 4 and bit 2 both at one while `eng_is_master` is low gives a one-cycle `cmd_release` pulse after the write. The stop request bit then reads zero.
- R8: A data write while the flag is low sets control bit 3 (collision) and leaves `tx_byte` unchanged. A data write while the flag is high loads `tx_byte` and clears bit 3. Control writes never change bit 3.
- R9: `cmd_ack_en` equals control bit 6 AND enable.
- R10: With enable at zero, `cmd_go`, `cmd_start`, `cmd_stop`, `cmd_release`, `cmd_ack_en` and `hold_scl` stay low, while control writes still update the stored bits.
- R11: Control bit 1 always reads zero.
- R12: One control write can clear the flag and set the start request together. The go pulse and `cmd_start` then both appear in the cycle after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the control register, 1 the data register |
| reg_wdata | input | DATA_W | Write data |
| ctl_rdata | output | 8 | Control register read value |
| tx_byte | output | DATA_W | Data register contents passed to the engine |
| glob_irq_en | input | 1 | Global interrupt enable |
| eng_done | input | 1 | Engine has finished its current job |
| eng_is_master | input | 1 | Engine is currently bus master |
| eng_start_seen | input | 1 | START event observed on the bus |
| eng_stop_seen | input | 1 | STOP event observed on the bus |
| eng_stop_done | input | 1 | Engine has executed a requested STOP |
| cmd_go | output | 1 | One-cycle pulse that launches the next operation |
| cmd_start | output | 1 | Request to generate a START |
| cmd_stop | output | 1 | Request to generate a STOP (master) |
| cmd_release | output | 1 | One-cycle pulse telling the engine to drop to unaddressed slave and float both lines |
| cmd_ack_en | output | 1 | Acknowledge generation enable |
| hold_scl | output | 1 | Keep the clock line stretched low |
| irq | output | 1 | Interrupt request |

## Verification
The engine's completion report and software's clear of the completion flag can land in the same cycle. The bench provokes this twice: once with the flag already low and once with it set. Both times `eng_done` is driven in the very cycle of a control write carrying bit 7 at one. It then judges that the flag reads set, `hold_scl` stays high and no go pulse appears. A separate vector merges the flag clear with a start request in one write, and it must yield go and start together.

// File: rtl/twb_ctrl_pkg.sv
package twb_ctrl_pkg;
    localparam int CTL_W  = 8;
    localparam int B_DONE = 7;
    localparam int B_ACK  = 6;
    localparam int B_STA  = 5;
    localparam int B_STO  = 4;
    localparam int B_WCOL = 3;
    localparam int B_EN   = 2;
    localparam int B_IE   = 0;

    typedef struct packed {
        logic done;
        logic ack;
        logic sta;
        logic sto;
        logic wcol;
        logic en;
        logic ie;
    } ctl_t;
endpackage

// File: rtl/twb_ctrl_regs.sv
module twb_ctrl_regs
    import twb_ctrl_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctl,
    input  logic              wr_dat,
    input  logic [DATA_W-1:0] wdata,
    input  logic              eng_done,
    input  logic              is_master,
    input  logic              stop_exec,
    output ctl_t              ctl,
    output logic [DATA_W-1:0] dat,
    output logic              clr_ev,
    output logic              rel_ev
);
    typedef struct packed {
        ctl_t              ctl;
        logic [DATA_W-1:0] dat;
    } st_t;

    st_t  s_d, s_q;
    logic en_new;

    always_comb begin
        s_d    = s_q;
        en_new = wr_ctl ? wdata[B_EN] : s_q.ctl.en;
        clr_ev = wr_ctl & wdata[B_DONE] & s_q.ctl.done & ~eng_done & en_new;
        rel_ev = wr_ctl & wdata[B_STO] & wdata[B_EN] & ~is_master;

        if (wr_ctl) begin
            s_d.ctl.ack = wdata[B_ACK];
            s_d.ctl.sta = wdata[B_STA];
            s_d.ctl.en  = wdata[B_EN];
            s_d.ctl.ie  = wdata[B_IE];
            s_d.ctl.sto = wdata[B_STO] & ~rel_ev;
        end else if (stop_exec) begin
            s_d.ctl.sto = 1'b0;
        end

        if (eng_done) begin
            s_d.ctl.done = 1'b1;
        end else if (wr_ctl && wdata[B_DONE]) begin
            s_d.ctl.done = 1'b0;
        end

        if (wr_dat) begin
            if (s_q.ctl.done) begin
                s_d.dat      = wdata;
                s_d.ctl.wcol = 1'b0;
            end else begin
                s_d.ctl.wcol = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ctl = s_q.ctl;
    assign dat = s_q.dat;

    a_r2_done_on_engine: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> ctl.done);
    a_r8_collision_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dat && !ctl.done) |=> (ctl.wcol && $stable(dat)));
    a_r6_stop_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_exec && !wr_ctl) |=> !ctl.sto);
endmodule

// File: rtl/twb_ctrl_busmon.sv
module twb_ctrl_busmon (
    input  logic clk,
    input  logic rst_n,
    input  logic start_seen,
    input  logic stop_seen,
    output logic busy
);
    typedef struct packed {
        logic busy;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (start_seen)     s_d.busy = 1'b1;
        else if (stop_seen) s_d.busy = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy = s_q.busy;

    a_r5_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        start_seen |=> busy);
    a_r5_idle_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_seen && !start_seen) |=> !busy);
endmodule

// File: rtl/twb_ctrl_cmd.sv
module twb_ctrl_cmd
    import twb_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  ctl_t ctl,
    input  logic busy,
    input  logic clr_ev,
    input  logic rel_ev,
    input  logic is_master,
    input  logic glob_irq_en,
    output logic cmd_go,
    output logic cmd_start,
    output logic cmd_stop,
    output logic cmd_release,
    output logic cmd_ack_en,
    output logic hold_scl,
    output logic irq
);
    typedef struct packed {
        logic go;
        logic rel;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.go  = clr_ev;
        s_d.rel = rel_ev;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cmd_go      = s_q.go;
    assign cmd_release = s_q.rel;
    assign cmd_start   = ctl.en & ctl.sta & ~busy;
    assign cmd_stop    = ctl.en & ctl.sto & is_master;
    assign cmd_ack_en  = ctl.en & ctl.ack;
    assign hold_scl    = ctl.en & ctl.done;
    assign irq         = ctl.done & ctl.ie & glob_irq_en;

    a_r3_go_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_go |-> (!ctl.done && $past(ctl.done) && ctl.en));
    a_r7_release_drops_stop: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_release |-> !ctl.sto);
endmodule

// File: rtl/twb_ctrl.sv
module twb_ctrl
    import twb_ctrl_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [CTL_W-1:0]  ctl_rdata,
    output logic [DATA_W-1:0] tx_byte,
    input  logic              glob_irq_en,
    input  logic              eng_done,
    input  logic              eng_is_master,
    input  logic              eng_start_seen,
    input  logic              eng_stop_seen,
    input  logic              eng_stop_done,
    output logic              cmd_go,
    output logic              cmd_start,
    output logic              cmd_stop,
    output logic              cmd_release,
    output logic              cmd_ack_en,
    output logic              hold_scl,
    output logic              irq
);
    ctl_t ctl;
    logic busy, clr_ev, rel_ev;
    logic wr_ctl, wr_dat;

    assign wr_ctl = reg_wr & ~reg_sel;
    assign wr_dat = reg_wr & reg_sel;

    twb_ctrl_regs #(.DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctl    (wr_ctl),
        .wr_dat    (wr_dat),
        .wdata     (reg_wdata),
        .eng_done  (eng_done),
        .is_master (eng_is_master),
        .stop_exec (eng_stop_done & eng_is_master),
        .ctl       (ctl),
        .dat       (tx_byte),
        .clr_ev    (clr_ev),
        .rel_ev    (rel_ev)
    );

    twb_ctrl_busmon u_busmon (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_seen (eng_start_seen),
        .stop_seen  (eng_stop_seen),
        .busy       (busy)
    );

    twb_ctrl_cmd u_cmd (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl         (ctl),
        .busy        (busy),
        .clr_ev      (clr_ev),
        .rel_ev      (rel_ev),
        .is_master   (eng_is_master),
        .glob_irq_en (glob_irq_en),
        .cmd_go      (cmd_go),
        .cmd_start   (cmd_start),
        .cmd_stop    (cmd_stop),
        .cmd_release (cmd_release),
        .cmd_ack_en  (cmd_ack_en),
        .hold_scl    (hold_scl),
        .irq         (irq)
    );

    assign ctl_rdata = {ctl.done, ctl.ack, ctl.sta, ctl.sto, ctl.wcol, ctl.en, 1'b0, ctl.ie};

    a_r10_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_rdata[B_EN] |-> !(cmd_start || cmd_stop || cmd_ack_en || hold_scl));
    a_r11_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_rdata[1]);
endmodule

// File: tb/twb_ctrl_tb_top.sv
module twb_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_sel = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] ctl_rdata, tx_byte;
    logic       glob_irq_en = 1'b0, eng_done = 1'b0, eng_is_master = 1'b0;
    logic       eng_start_seen = 1'b0, eng_stop_seen = 1'b0, eng_stop_done = 1'b0;
    logic       cmd_go, cmd_start, cmd_stop, cmd_release, cmd_ack_en, hold_scl, irq;
    int         n_chk = 0, n_fail = 0;
    bit         done_run = 1'b0;

    always #5 clk = ~clk;

    twb_ctrl #(.DATA_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .ctl_rdata(ctl_rdata), .tx_byte(tx_byte),
        .glob_irq_en(glob_irq_en), .eng_done(eng_done), .eng_is_master(eng_is_master),
        .eng_start_seen(eng_start_seen), .eng_stop_seen(eng_stop_seen),
        .eng_stop_done(eng_stop_done), .cmd_go(cmd_go), .cmd_start(cmd_start),
        .cmd_stop(cmd_stop), .cmd_release(cmd_release), .cmd_ack_en(cmd_ack_en),
        .hold_scl(hold_scl), .irq(irq)
    );

    // wr, sel, wdata, {done, start_seen, stop_seen, stop_done, master, gie},
    // expected ctl, {start, go, hold, irq, stop}
    localparam int NV = 15;
    localparam logic [28:0] VEC [NV] = '{
        {1'b1, 1'b0, 8'h05, 6'b000001, 8'h05, 5'b00000},
        {1'b0, 1'b0, 8'h00, 6'b100001, 8'h85, 5'b00110},
        {1'b0, 1'b0, 8'h00, 6'b000000, 8'h85, 5'b00100},
        {1'b1, 1'b0, 8'h85, 6'b000000, 8'h05, 5'b01000},
        {1'b0, 1'b0, 8'h00, 6'b000000, 8'h05, 5'b00000},
        {1'b0, 1'b0, 8'h00, 6'b010000, 8'h05, 5'b00000},
        {1'b1, 1'b0, 8'h25, 6'b000000, 8'h25, 5'b00000},
        {1'b0, 1'b0, 8'h00, 6'b001000, 8'h25, 5'b10000},
        {1'b1, 1'b0, 8'h05, 6'b000000, 8'h05, 5'b00000},
        {1'b1, 1'b0, 8'h15, 6'b000010, 8'h15, 5'b00001},
        {1'b0, 1'b0, 8'h00, 6'b000110, 8'h05, 5'b00000},
        {1'b1, 1'b0, 8'h85, 6'b100000, 8'h85, 5'b00100},
        {1'b1, 1'b0, 8'h05, 6'b000000, 8'h85, 5'b00100},
        {1'b1, 1'b0, 8'h85, 6'b100000, 8'h85, 5'b00100},
        {1'b1, 1'b0, 8'hA5, 6'b000000, 8'h25, 5'b11000}
    };

    task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic wr_reg(input logic sel, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(posedge clk); #2;
        reg_wr = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        eng_done = 1'b1;
        @(posedge clk); #2;
        eng_done = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done_run) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // R1 reset state
        chk("R1 ctl", ctl_rdata, 8'h00);
        chk("R1 tx", tx_byte, 8'h00);
        chk("R1 outputs", {1'b0, cmd_go, cmd_start, cmd_stop, cmd_release, cmd_ack_en, hold_scl, irq}, 8'h00);

        // Vector walk: R2 R3 R4 R5 R6 R12
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            reg_wr = VEC[i][28]; reg_sel = VEC[i][27]; reg_wdata = VEC[i][26:19];
            {eng_done, eng_start_seen, eng_stop_seen, eng_stop_done, eng_is_master, glob_irq_en} = VEC[i][18:13];
            @(posedge clk); #2;
            chk($sformatf("vec %0d ctl (R2 R5 R6)", i), ctl_rdata, VEC[i][12:5]);
            chk($sformatf("vec %0d start (R5 R12)", i), {7'b0, cmd_start}, {7'b0, VEC[i][4]});
            chk($sformatf("vec %0d go (R3 R12)", i), {7'b0, cmd_go}, {7'b0, VEC[i][3]});
            chk($sformatf("vec %0d hold (R3)", i), {7'b0, hold_scl}, {7'b0, VEC[i][2]});
            chk($sformatf("vec %0d irq (R4)", i), {7'b0, irq}, {7'b0, VEC[i][1]});
            chk($sformatf("vec %0d stop (R6)", i), {7'b0, cmd_stop}, {7'b0, VEC[i][0]});
            reg_wr = 1'b0;
            {eng_done, eng_start_seen, eng_stop_seen, eng_stop_done, eng_is_master, glob_irq_en} = 6'b0;
        end

        // R8 collision with flag low
        wr_reg(1'b1, 8'h3C);
        chk("R8 wcol set", ctl_rdata, 8'h2D);
        chk("R8 tx unchanged", tx_byte, 8'h00);
        pulse_done();
        wr_reg(1'b1, 8'h5A);
        chk("R8 wcol cleared", ctl_rdata, 8'hA5);
        chk("R8 tx loaded", tx_byte, 8'h5A);
        wr_reg(1'b0, 8'h0D);
        chk("R8 ctl write leaves wcol, R2 zero keeps flag", ctl_rdata, 8'h85);

        // R7 slave stop
        eng_is_master = 1'b0;
        wr_reg(1'b0, 8'h15);
        chk("R7 release pulse", {7'b0, cmd_release}, 8'h01);
        chk("R7 stop bit zero", ctl_rdata, 8'h85);
        chk("R7 no master stop", {7'b0, cmd_stop}, 8'h00);
        @(posedge clk); #2;
        chk("R7 release one cycle", {7'b0, cmd_release}, 8'h00);

        // R9 acknowledge enable
        wr_reg(1'b0, 8'h45);
        chk("R9 ack on", {7'b0, cmd_ack_en}, 8'h01);
        chk("R9 ctl", ctl_rdata, 8'hC5);

        // R10 disabled interface
        wr_reg(1'b0, 8'h41);
        chk("R10 ack off", {7'b0, cmd_ack_en}, 8'h00);
        chk("R10 hold off", {7'b0, hold_scl}, 8'h00);
        chk("R10 bits stored", ctl_rdata, 8'hC1);
        wr_reg(1'b0, 8'hE1);
        chk("R10 no go", {7'b0, cmd_go}, 8'h00);
        chk("R10 no start", {7'b0, cmd_start}, 8'h00);
        chk("R10 clear stored", ctl_rdata, 8'h61);

        // R11 reserved bit
        wr_reg(1'b0, 8'h02);
        chk("R11 reserved reads zero", ctl_rdata, 8'h00);

        done_run = 1'b1;
        finish_run();
    end
endmodule